// File: doc/BRIEF.md
# Asynchronous Static Memory Access Sequencer

This block runs one read or one write to an asynchronous static-memory device and shapes every strobe edge from a 32-bit timing word. The host raises `start` for one cycle with the direction, address, write data and timing word. The block drives the address and an address-valid flag. It then runs the active-low chip select, the read or write strobe and a bus-start marker through a fixed order of phases. A read returns the device's data on `rdata`. `done` pulses once when the access has finished.

The phases always come in the same order: address setup, strobe lead, strobe active, strobe trail, address hold, completion. The timing word gives each phase its own length, and a phase of length zero is skipped. The length of the strobe-active phase comes from a 4-bit code whose table is not linear, so long waits can be reached with few bits. All device-side outputs come straight from flip-flops.

Top module: `sram_cycle_gen`

## Requirements
- R1: After a synchronous reset, `dev_csn`, `dev_rdn`, `dev_wen` and `dev_bsn` are 1, and `dev_adv`, `dev_doe` and `done` are 0.
- R2: In the cycle after `start` is sampled while idle, `dev_adv` rises with `dev_addr` equal to the sampled address. It stays high for S cycles before `dev_csn` falls, where S is timing bits 30:28 (0 to 7).
- R3: On a read, `dev_rdn` falls A cycles after `dev_csn` falls (A = bits 22:20). It stays low for W+1 cycles. `dev_csn` rises B cycles after `dev_rdn` rises (B = bits 18:16). `dev_wen` stays 1.
- R4: On a write, `dev_wen` falls A cycles after `dev_csn` falls (A = bits 14:12). It stays low for W+1 cycles. `dev_csn` rises B cycles after `dev_wen` rises (B = bits 10:8). `dev_doe` is 1 exactly while `dev_csn` is low, with `dev_wdata` equal to the sampled write data. `dev_rdn` stays 1.
- R5: W comes from code bits 3:0. Codes 0 to 9 give W equal to the code. Codes 10 to 15 give 11, 13, 15, 17, 21 and 25.
- R6: `dev_bsn` falls in the same cycle as `dev_csn`. It stays low for 1 cycle when bit 4 is 0 and for 2 cycles when bit 4 is 1. It is never low while `dev_csn` is high, so a one-cycle select gives a one-cycle marker.
- R7: After `dev_csn` rises, `dev_adv` stays high with the address unchanged for H cycles (H = bits 26:24).
- R8: `done` is high for exactly one cycle, the cycle after the hold phase ends. In that cycle all strobes are 1 and `dev_adv` is 0. The block is idle in the cycle after.
- R9: On a read, `rdata` takes the value of `dev_rdata` present in the last cycle with `dev_rdn` low. It is valid while `done` is high. A write leaves `rdata` unchanged.
- R10: From the cycle after `start` is accepted until the end of the `done` cycle, `start`, `wr`, `addr`, `wdata` and `cfg` are ignored. The access uses the values sampled when it was accepted.
- R11: Timing bits 31, 27, 23, 19, 15, 11 and 7:5 have no effect. A phase of zero length takes no cycle, and the next phase starts at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an access (sampled while idle) |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Access address |
| wdata | input | DATA_W | Write data |
| cfg | input | 32 | Timing word |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Captured read data |
| dev_adv | output | 1 | Address valid to device |
| dev_addr | output | ADDR_W | Device address |
| dev_wdata | output | DATA_W | Device write data |
| dev_doe | output | 1 | Write data drive enable |
| dev_csn | output | 1 | Chip select, active low |
| dev_rdn | output | 1 | Read strobe, active low |
| dev_wen | output | 1 | Write enable, active low |
| dev_bsn | output | 1 | Bus-start marker, active low |
| dev_rdata | input | DATA_W | Read data from device |

## Verification
Some rules hold on every cycle, and the in-line assertions check those. A strobe or the bus-start marker is only ever low inside chip select. Address-valid covers chip select. `done` is a lone quiet pulse followed by idle. The latched timing and `rdata` stay still except at acceptance and capture. Other behaviour only the bench scenarios can show: how many cycles each phase lasts, the non-linear wait table, where the bus-start marker is cut short, which data sample is captured, and that the unused timing bits and a `start` during an access change nothing. The bench checks these against a per-cycle expected waveform built from the timing word.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;

  localparam int CNT_W = 5;  // holds the longest phase (25 + 1 strobe cycles)

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_LEAD, PH_STROBE, PH_TRAIL, PH_HOLD, PH_DONE
  } phase_t;

  typedef struct packed {
    logic [2:0] ads;
    logic [2:0] adh;
    logic [2:0] rds;
    logic [2:0] rdh;
    logic [2:0] wts;
    logic [2:0] wth;
    logic       bsh;
    logic [3:0] wcode;
  } timing_t;

  function automatic timing_t unpack_timing(input logic [31:0] w);
    timing_t t;
    t.ads   = w[30:28];
    t.adh   = w[26:24];
    t.rds   = w[22:20];
    t.rdh   = w[18:16];
    t.wts   = w[14:12];
    t.wth   = w[10:8];
    t.bsh   = w[4];
    t.wcode = w[3:0];
    return t;
  endfunction

  // Non-linear code: identity up to 9, then steps of 2 up to 17, then 21, 25.
  function automatic logic [CNT_W-1:0] wait_cycles(input logic [3:0] c);
    if (c <= 4'd9)       return CNT_W'(c);
    else if (c <= 4'd13) return CNT_W'({c, 1'b0} - 5'd9);
    else if (c == 4'd14) return CNT_W'(21);
    else                 return CNT_W'(25);
  endfunction

endpackage

// File: rtl/sram_cyc_seq.sv
module sram_cyc_seq
  import sram_cyc_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    wr,
  input  timing_t cfg,
  output phase_t  phase,
  output phase_t  phase_nxt,
  output logic    eff_wr,
  output logic    eff_bsh,
  output logic    accept,
  output logic    last_strobe
);

  timing_t          t_q;
  timing_t          eff;
  logic             wr_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             idle;
  phase_t           cand;

  function automatic logic [CNT_W-1:0] ph_len(input phase_t p, input timing_t t, input logic w);
    case (p)
      PH_SETUP:  return CNT_W'(t.ads);
      PH_LEAD:   return CNT_W'(w ? t.wts : t.rds);
      PH_STROBE: return wait_cycles(t.wcode) + CNT_W'(1);
      PH_TRAIL:  return CNT_W'(w ? t.wth : t.rdh);
      PH_HOLD:   return CNT_W'(t.adh);
      PH_DONE:   return CNT_W'(1);
      default:   return '0;
    endcase
  endfunction

  function automatic phase_t next_ph(input phase_t p);
    case (p)
      PH_SETUP:  return PH_LEAD;
      PH_LEAD:   return PH_STROBE;
      PH_STROBE: return PH_TRAIL;
      PH_TRAIL:  return PH_HOLD;
      PH_HOLD:   return PH_DONE;
      default:   return PH_IDLE;
    endcase
  endfunction

  always_comb begin
    idle        = (phase == PH_IDLE);
    eff         = idle ? cfg : t_q;
    eff_wr      = idle ? wr : wr_q;
    eff_bsh     = eff.bsh;
    accept      = idle && start;
    last_strobe = (phase == PH_STROBE) && (cnt == '0);
    phase_nxt   = phase;
    cnt_nxt     = idle ? '0 : cnt - CNT_W'(1);
    cand        = PH_IDLE;
    if (accept || (!idle && cnt == '0)) begin
      cand = accept ? PH_SETUP : next_ph(phase);
      // at most two zero-length phases can follow each other
      for (int i = 0; i < 2; i++) begin
        if (cand != PH_IDLE && ph_len(cand, eff, eff_wr) == '0)
          cand = next_ph(cand);
      end
      phase_nxt = cand;
      cnt_nxt   = (cand == PH_IDLE) ? '0 : ph_len(cand, eff, eff_wr) - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      t_q   <= '0;
      wr_q  <= 1'b0;
    end else begin
      phase <= phase_nxt;
      cnt   <= cnt_nxt;
      if (accept) begin
        t_q  <= cfg;
        wr_q <= wr;
      end
    end
  end

  a_r10_timing_held: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |=> ($stable(t_q) && $stable(wr_q)));
  a_r8_done_then_idle: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DONE) |=> (phase == PH_IDLE));

endmodule

// File: rtl/sram_cyc_strobe.sv
module sram_cyc_strobe
  import sram_cyc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t phase_nxt,
  input  logic   wr_nxt,
  input  logic   bsh_nxt,
  output logic   csn,
  output logic   rdn,
  output logic   wen,
  output logic   bsn,
  output logic   adv,
  output logic   doe,
  output logic   done
);

  logic cs_on;
  logic strobe_on;
  logic cs_first;

  always_comb begin
    cs_on     = (phase_nxt == PH_LEAD) || (phase_nxt == PH_STROBE) || (phase_nxt == PH_TRAIL);
    strobe_on = (phase_nxt == PH_STROBE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      csn      <= 1'b1;
      rdn      <= 1'b1;
      wen      <= 1'b1;
      bsn      <= 1'b1;
      adv      <= 1'b0;
      doe      <= 1'b0;
      done     <= 1'b0;
      cs_first <= 1'b0;
    end else begin
      csn      <= !cs_on;
      rdn      <= !(strobe_on && !wr_nxt);
      wen      <= !(strobe_on && wr_nxt);
      adv      <= cs_on || (phase_nxt == PH_SETUP) || (phase_nxt == PH_HOLD);
      doe      <= cs_on && wr_nxt;
      done     <= (phase_nxt == PH_DONE);
      bsn      <= !(cs_on && (csn || (bsh_nxt && cs_first)));
      cs_first <= cs_on && csn;
    end
  end

  a_r3_rd_inside_cs: assert property (@(posedge clk) disable iff (rst) !rdn |-> !csn);
  a_r4_we_inside_cs: assert property (@(posedge clk) disable iff (rst) !wen |-> !csn);
  a_r4_one_strobe:   assert property (@(posedge clk) disable iff (rst) !(!rdn && !wen));
  a_r6_bs_inside_cs: assert property (@(posedge clk) disable iff (rst) !bsn |-> !csn);
  a_r6_bs_on_cs:     assert property (@(posedge clk) disable iff (rst) $fell(csn) |-> !bsn);
  a_r2_adv_cover:    assert property (@(posedge clk) disable iff (rst) !csn |-> adv);
  a_r8_done_pulse:   assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r8_done_quiet:   assert property (@(posedge clk) disable iff (rst)
    done |-> (csn && rdn && wen && bsn && !adv));

endmodule

// File: rtl/sram_cycle_gen.sv
module sram_cycle_gen
  import sram_cyc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [31:0]       cfg,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              dev_adv,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [DATA_W-1:0] dev_wdata,
  output logic              dev_doe,
  output logic              dev_csn,
  output logic              dev_rdn,
  output logic              dev_wen,
  output logic              dev_bsn,
  input  logic [DATA_W-1:0] dev_rdata
);

  phase_t phase;
  phase_t phase_nxt;
  logic   eff_wr;
  logic   eff_bsh;
  logic   accept;
  logic   last_strobe;
  logic   capture;

  sram_cyc_seq u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .wr          (wr),
    .cfg         (unpack_timing(cfg)),
    .phase       (phase),
    .phase_nxt   (phase_nxt),
    .eff_wr      (eff_wr),
    .eff_bsh     (eff_bsh),
    .accept      (accept),
    .last_strobe (last_strobe)
  );

  sram_cyc_strobe u_strobe (
    .clk       (clk),
    .rst       (rst),
    .phase_nxt (phase_nxt),
    .wr_nxt    (eff_wr),
    .bsh_nxt   (eff_bsh),
    .csn       (dev_csn),
    .rdn       (dev_rdn),
    .wen       (dev_wen),
    .bsn       (dev_bsn),
    .adv       (dev_adv),
    .doe       (dev_doe),
    .done      (done)
  );

  assign capture = last_strobe && !eff_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      dev_addr  <= '0;
      dev_wdata <= '0;
      rdata     <= '0;
    end else begin
      if (accept) begin
        dev_addr  <= addr;
        dev_wdata <= wdata;
      end
      if (capture) rdata <= dev_rdata;
    end
  end

  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(rdata));
  a_r9_capture_in_read: assert property (@(posedge clk) disable iff (rst)
    capture |-> (!dev_rdn && dev_wen));
  a_r7_addr_steady: assert property (@(posedge clk) disable iff (rst)
    (dev_adv && $past(dev_adv)) |-> $stable(dev_addr));

endmodule

// File: tb/sram_cycle_gen_test.sv
module sram_cycle_gen_test;

  localparam int AW = 24;
  localparam int DW = 16;

  typedef struct {
    logic [6:0] v;     // {csn, rdn, wen, bsn, adv, doe, done}
    logic       last;  // last read-strobe cycle
    string      tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [31:0]   cfg = '0;
  logic          done;
  logic [DW-1:0] rdata;
  logic          dev_adv, dev_doe, dev_csn, dev_rdn, dev_wen, dev_bsn;
  logic [AW-1:0] dev_addr;
  logic [DW-1:0] dev_wdata;
  logic [DW-1:0] dev_rdata;

  int            checks = 0;
  int            failures = 0;
  int            cyc = 0;
  bit            chk_en = 1'b0;
  exp_t          q[$];
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_wdata;
  logic [DW-1:0] exp_rdata = '0;
  int            wtab[16] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 9, 11, 13, 15, 17, 21, 25};

  always #10 clk = ~clk;  // 50 MHz

  assign dev_rdata = DW'(cyc) ^ 16'h5A00;

  sram_cycle_gen #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .start(start), .wr(wr), .addr(addr), .wdata(wdata),
    .cfg(cfg), .done(done), .rdata(rdata), .dev_adv(dev_adv), .dev_addr(dev_addr),
    .dev_wdata(dev_wdata), .dev_doe(dev_doe), .dev_csn(dev_csn), .dev_rdn(dev_rdn),
    .dev_wen(dev_wen), .dev_bsn(dev_bsn), .dev_rdata(dev_rdata)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      failures++;
      $display("FAIL R8 watchdog: actual=no completion expected=completion");
      summary();
      $finish;
    end
  end

  // per-cycle comparison against the expected waveform
  always @(negedge clk) begin
    if (chk_en) begin
      exp_t e;
      logic [6:0] act;
      if (q.size() > 0) e = q.pop_front();
      else begin
        e.v = 7'b1111000; e.last = 1'b0; e.tag = "R10 idle";
      end
      act = {dev_csn, dev_rdn, dev_wen, dev_bsn, dev_adv, dev_doe, done};
      checks++;
      if (act !== e.v) begin
        failures++;
        $display("FAIL %s strobes: actual=%b expected=%b", e.tag, act, e.v);
      end
      if (e.v[2]) begin
        checks++;
        if (dev_addr !== cur_addr) begin
          failures++;
          $display("FAIL R2/R7 address: actual=%h expected=%h", dev_addr, cur_addr);
        end
      end
      if (e.v[1]) begin
        checks++;
        if (dev_wdata !== cur_wdata) begin
          failures++;
          $display("FAIL R4 write data: actual=%h expected=%h", dev_wdata, cur_wdata);
        end
      end
      if (e.last) exp_rdata = dev_rdata;
      if (e.v[0]) begin
        checks++;
        if (rdata !== exp_rdata) begin
          failures++;
          $display("FAIL R9 rdata: actual=%h expected=%h", rdata, exp_rdata);
        end
      end
    end
  end

  task automatic push(input logic [6:0] v, input logic last, input string tag);
    exp_t e;
    e.v = v; e.last = last; e.tag = tag;
    q.push_back(e);
  endtask

  // Builds the expected cycle list from the field positions in the requirements.
  task automatic build(input logic w, input logic [31:0] c);
    int ads = int'(c[30:28]);
    int adh = int'(c[26:24]);
    int lead = w ? int'(c[14:12]) : int'(c[22:20]);
    int trail = w ? int'(c[10:8]) : int'(c[18:16]);
    int sw = wtab[c[3:0]] + 1;     // R5
    int bsl = c[4] ? 2 : 1;        // R6
    int k = 0;
    string st = w ? "R4" : "R3";
    for (int i = 0; i < ads; i++) push(7'b1111100, 1'b0, "R2 setup");
    for (int i = 0; i < lead; i++) begin
      push({1'b0, 1'b1, 1'b1, !(k < bsl), 1'b1, w, 1'b0}, 1'b0, {st, " lead"}); k++;
    end
    for (int i = 0; i < sw; i++) begin
      push({1'b0, w, !w, !(k < bsl), 1'b1, w, 1'b0}, (i == sw - 1) && !w, {st, "/R5 strobe"}); k++;
    end
    for (int i = 0; i < trail; i++) begin
      push({1'b0, 1'b1, 1'b1, !(k < bsl), 1'b1, w, 1'b0}, 1'b0, {st, " trail"}); k++;
    end
    for (int i = 0; i < adh; i++) push(7'b1111100, 1'b0, "R7 hold");
    push(7'b1111001, 1'b0, "R8 done");
  endtask

  task automatic access(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [31:0] c, input bit poke);
    @(negedge clk);
    start = 1'b1; wr = w; addr = a; wdata = d; cfg = c;
    cur_addr = a; cur_wdata = d;
    @(posedge clk);
    #1;
    start = 1'b0;
    build(w, c);
    if (poke) begin
      // R10: a second request during the access with other values
      @(negedge clk);
      start = 1'b1; wr = !w; addr = ~a; wdata = ~d; cfg = 32'h0000_0000;
      @(negedge clk);
      start = 1'b0;
    end
    while (q.size() > 0) begin
      @(negedge clk);
      #2;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk_en = 1'b1;  // first compares are the R1 reset state
    repeat (2) @(negedge clk);

    // all fields zero: one-cycle select, R11 skipping
    access(1'b0, 24'h00_1234, 16'h0000, 32'h0000_0000, 1'b0);
    // all maximum read and write, R5 code 15 and two-cycle R6 marker
    access(1'b0, 24'hAB_CDEF, 16'h0000, 32'h7777_771F, 1'b0);
    access(1'b1, 24'h12_3456, 16'hBEEF, 32'h7777_771F, 1'b0);
    // mixed write, zero trail and hold skipped (R11)
    access(1'b1, 24'h00_0F0F, 16'h1357, 32'h2000_301A, 1'b1);
    // R6 marker cut to the single select cycle
    access(1'b0, 24'h55_0000, 16'h0000, 32'h0000_0010, 1'b0);
    // R11 unused timing bits set: same timing as 0x1412_0033
    access(1'b0, 24'h77_7777, 16'h0000, 32'h9C9A_88F3, 1'b1);
    // R5 every wait code, read and write
    for (int code = 0; code < 16; code++) begin
      access(code[0], AW'(code * 3 + 5), DW'(code * 7), 32'h1312_2100 | 32'(code), 1'b0);
    end
    // R10 busy request during a long read
    access(1'b0, 24'h3C_3C3C, 16'h0000, 32'h3203_0008, 1'b1);
    repeat (3) @(negedge clk);

    summary();
    $finish;
  end

endmodule